// File: doc/BRIEF.md
# Multi-slot inter-processor mailbox

This block lets two processor cores pass fixed-length messages through a bank of independent slots. Each slot has a control word and an eight-word message buffer. Both are reached over a plain 32-bit register bus with write and read strobes, a byte address, write data and registered read data. Every slot owns a 64-byte window. The control word sits at the start of the window, and the message words follow at 4-byte steps.

The control word holds two things. The first is a one-hot lifecycle field in bits [7:4], with four states: SLOT_IDLE (0x1), SLOT_TX (0x2), SLOT_RX (0x4) and SLOT_ACK (0x8). The second is a completion-mode bit in bit 0, where 1 means automatic completion and 0 means completion by interrupt.

A sender moves a slot to SLOT_TX, picks the completion mode, fills the buffer and notifies its peer. The receiving core reports its progress on a side port that carries a slot index and two strobes. The claim strobe takes the slot from SLOT_TX to SLOT_RX. The done strobe ends the transfer. In automatic mode, done returns the slot to SLOT_IDLE in hardware, and a polling sender sees completion when the field reads back as idle. In interrupt mode, done parks the slot in SLOT_ACK and raises that slot's pending-acknowledge flag. The sender's software then writes SLOT_IDLE back.

Top module: `mbx_top`

## Requirements
- R1: After reset every slot's control word reads 0x10 (idle, interrupt mode), every message word reads 0, and both the tx_pend and ack_pend vectors are 0.
- R2: The slot s window starts at byte address s*0x40, with the control word at offset 0x00 and message word i at offset 0x04+4*i. bus_rdata takes the addressed value in the cycle after bus_rd is sampled.
- R3: A control-word write always loads bit 0 from wdata[0]. It loads the state field from wdata[7:4] only when that value is 0x1, 0x2, 0x4 or 0x8, and otherwise leaves the state unchanged. All other bits read as 0.
- R4: Message words can be read and written in every state. Offsets 0x24 to 0x3C of a window read 0 and ignore writes, and an access whose address bits [1:0] are not zero is ignored and reads 0.
- R5: A claim strobe for a slot in SLOT_TX moves it to SLOT_RX on the next edge.
- R6: A done strobe for a slot in SLOT_TX or SLOT_RX whose mode bit is 1 moves it to SLOT_IDLE on the next edge.
- R7: A done strobe for a slot in SLOT_TX or SLOT_RX whose mode bit is 0 moves it to SLOT_ACK, and ack_pend[s] is high while the slot is in SLOT_ACK. A software write of idle clears it.
- R8: Claim and done strobes have no effect on a slot in SLOT_IDLE or SLOT_ACK, and claim has no effect in SLOT_RX.
- R9: When a bus write to a slot's control word and a strobe for the same slot land in the same cycle, the bus write decides the next state.
- R10: tx_pend[s] is high exactly while slot s is in SLOT_TX.
- R11: bus_rdata changes only in the cycle after a cycle with bus_rd high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | 11 | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| rx_slot | input | 5 | Slot addressed by the receiver strobes |
| rx_claim | input | 1 | Receiver has taken the message |
| rx_done | input | 1 | Receiver has finished reading |
| tx_pend | output | 32 | Per-slot flag, slot in SLOT_TX |
| ack_pend | output | 32 | Per-slot flag, slot in SLOT_ACK |

## Verification
A wrong lifecycle state shows up on the next read of the control word. For the transmit and acknowledge states it also appears at once on tx_pend or ack_pend, one edge after the write or strobe that caused it. A mis-decoded address shows up as a message word landing in a neighbour's window, and a read of that neighbour exposes it one cycle later. A lost or misplaced field update, for example a write that clears the state or a done strobe that ignores the mode bit, can hide until the sender polls. For that reason each scenario reads the control word back immediately after each strobe.

// File: rtl/mbx_pkg.sv
package mbx_pkg;

    typedef enum logic [3:0] {
        SLOT_IDLE = 4'b0001,
        SLOT_TX   = 4'b0010,
        SLOT_RX   = 4'b0100,
        SLOT_ACK  = 4'b1000
    } slot_state_e;

    function automatic logic is_state_code(input logic [3:0] v);
        return (v == SLOT_IDLE) || (v == SLOT_TX) || (v == SLOT_RX) || (v == SLOT_ACK);
    endfunction

endpackage

// File: rtl/mbx_slot_fsm.sv
module mbx_slot_fsm
    import mbx_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        mode_we,
    input  logic [3:0]  wr_state,
    input  logic        wr_auto,
    input  logic        hw_claim,
    input  logic        hw_done,
    output slot_state_e state,
    output logic        auto_ack
);

    slot_state_e state_nxt;
    logic        auto_nxt;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= SLOT_IDLE;
            auto_ack <= 1'b0;
        end else begin
            state    <= state_nxt;
            auto_ack <= auto_nxt;
        end
    end

    always_comb begin
        state_nxt = state;
        auto_nxt  = auto_ack;
        if (mode_we) begin
            auto_nxt = wr_auto;
            if (is_state_code(wr_state))
                state_nxt = slot_state_e'(wr_state);
        end else begin
            unique case (state)
                SLOT_TX: begin
                    if (hw_done)
                        state_nxt = auto_ack ? SLOT_IDLE : SLOT_ACK;
                    else if (hw_claim)
                        state_nxt = SLOT_RX;
                end
                SLOT_RX: begin
                    if (hw_done)
                        state_nxt = auto_ack ? SLOT_IDLE : SLOT_ACK;
                end
                SLOT_IDLE, SLOT_ACK: state_nxt = state;
                default: state_nxt = SLOT_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/mbx_msg_store.sv
module mbx_msg_store #(
    parameter int NUM_SLOTS = 32,
    parameter int MSG_WORDS = 8,
    parameter int DATA_W    = 32,
    localparam int SLOT_W   = $clog2(NUM_SLOTS),
    localparam int MW_W     = $clog2(MSG_WORDS),
    localparam int DEPTH    = NUM_SLOTS * MSG_WORDS
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [SLOT_W-1:0] wslot,
    input  logic [MW_W-1:0]   wword,
    input  logic [DATA_W-1:0] wdata,
    input  logic [SLOT_W-1:0] rslot,
    input  logic [MW_W-1:0]   rword,
    output logic [DATA_W-1:0] rdata
);

    logic [DATA_W-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int k = 0; k < DEPTH; k++)
                mem[k] <= '0;
        end else if (we) begin
            mem[{wslot, wword}] <= wdata;
        end
    end

    assign rdata = mem[{rslot, rword}];

endmodule

// File: rtl/mbx_top.sv
module mbx_top
    import mbx_pkg::*;
#(
    parameter int NUM_SLOTS      = 32,
    parameter int MSG_WORDS      = 8,
    parameter int DATA_W         = 32,
    parameter int SLOT_WIN_BYTES = 64,
    localparam int SLOT_W        = $clog2(NUM_SLOTS),
    localparam int WIN_LSB       = $clog2(SLOT_WIN_BYTES),
    localparam int WORD_W        = WIN_LSB - 2,
    localparam int MW_W          = $clog2(MSG_WORDS),
    localparam int ADDR_W        = SLOT_W + WIN_LSB
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 bus_wr,
    input  logic                 bus_rd,
    input  logic [ADDR_W-1:0]    bus_addr,
    input  logic [DATA_W-1:0]    bus_wdata,
    output logic [DATA_W-1:0]    bus_rdata,
    input  logic [SLOT_W-1:0]    rx_slot,
    input  logic                 rx_claim,
    input  logic                 rx_done,
    output logic [NUM_SLOTS-1:0] tx_pend,
    output logic [NUM_SLOTS-1:0] ack_pend
);

    logic [SLOT_W-1:0]      a_slot;
    logic [WORD_W-1:0]      a_word;
    logic [WORD_W-1:0]      a_didx;
    logic                   aligned, is_mode, is_data;
    logic [DATA_W-1:0]      store_rdata, rd_val;
    slot_state_e            st [NUM_SLOTS];
    logic [NUM_SLOTS-1:0]   ack_flat;
    logic [NUM_SLOTS*4-1:0] st_flat;

    assign a_slot  = bus_addr[ADDR_W-1:WIN_LSB];
    assign a_word  = bus_addr[WIN_LSB-1:2];
    assign aligned = (bus_addr[1:0] == 2'b00);
    assign is_mode = aligned && (a_word == '0);
    assign is_data = aligned && (a_word != '0) && (int'(a_word) <= MSG_WORDS);
    assign a_didx  = a_word - WORD_W'(1);

    for (genvar i = 0; i < NUM_SLOTS; i++) begin : g_slot
        mbx_slot_fsm u_fsm (
            .clk      (clk),
            .rst_n    (rst_n),
            .mode_we  (bus_wr && is_mode && (a_slot == SLOT_W'(i))),
            .wr_state (bus_wdata[7:4]),
            .wr_auto  (bus_wdata[0]),
            .hw_claim (rx_claim && (rx_slot == SLOT_W'(i))),
            .hw_done  (rx_done && (rx_slot == SLOT_W'(i))),
            .state    (st[i]),
            .auto_ack (ack_flat[i])
        );
        assign st_flat[i*4 +: 4] = st[i];
        assign tx_pend[i]        = (st[i] == SLOT_TX);
        assign ack_pend[i]       = (st[i] == SLOT_ACK);
    end

    mbx_msg_store #(
        .NUM_SLOTS (NUM_SLOTS),
        .MSG_WORDS (MSG_WORDS),
        .DATA_W    (DATA_W)
    ) u_store (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (bus_wr && is_data),
        .wslot (a_slot),
        .wword (a_didx[MW_W-1:0]),
        .wdata (bus_wdata),
        .rslot (a_slot),
        .rword (a_didx[MW_W-1:0]),
        .rdata (store_rdata)
    );

    always_comb begin
        if (is_mode)
            rd_val = {{(DATA_W-8){1'b0}}, st[a_slot], 3'b000, ack_flat[a_slot]};
        else if (is_data)
            rd_val = store_rdata;
        else
            rd_val = '0;
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            bus_rdata <= '0;
        else if (bus_rd)
            bus_rdata <= rd_val;
    end

endmodule

// File: rtl/mbx_top_chk.sv
module mbx_top_chk #(
    parameter int NUM_SLOTS = 32,
    parameter int DATA_W    = 32,
    parameter int ADDR_W    = 11,
    parameter int WIN_LSB   = 6,
    localparam int SLOT_W   = $clog2(NUM_SLOTS)
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 bus_wr,
    input logic                 bus_rd,
    input logic [ADDR_W-1:0]    bus_addr,
    input logic [3:0]           wr_state,
    input logic [DATA_W-1:0]    bus_rdata,
    input logic [SLOT_W-1:0]    rx_slot,
    input logic                 rx_claim,
    input logic                 rx_done,
    input logic [NUM_SLOTS*4-1:0] st_flat,
    input logic [NUM_SLOTS-1:0] ack_flat
);

    logic mode_word;
    assign mode_word = (bus_addr[WIN_LSB-1:0] == '0);

    AST_RDATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_rd |=> $stable(bus_rdata)); // R11

    for (genvar i = 0; i < NUM_SLOTS; i++) begin : g_chk
        logic [3:0] s;
        logic       hit, mine;
        assign s    = st_flat[i*4 +: 4];
        assign hit  = bus_wr && mode_word && (bus_addr[ADDR_W-1:WIN_LSB] == SLOT_W'(i));
        assign mine = (rx_slot == SLOT_W'(i));

        AST_STATE_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
            $countones(s) == 1); // R3

        AST_AUTO_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
            (rx_done && mine && !hit && ack_flat[i] && (s == 4'h2 || s == 4'h4))
            |=> (s == 4'h1)); // R6

        AST_IRQ_ACK: assert property (@(posedge clk) disable iff (!rst_n)
            (rx_done && mine && !hit && !ack_flat[i] && (s == 4'h2 || s == 4'h4))
            |=> (s == 4'h8)); // R7

        AST_CLAIM_RX: assert property (@(posedge clk) disable iff (!rst_n)
            (rx_claim && !rx_done && mine && !hit && s == 4'h2) |=> (s == 4'h4)); // R5

        AST_STROBE_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
            ((rx_claim || rx_done) && mine && !hit && (s == 4'h1 || s == 4'h8))
            |=> $stable(s)); // R8

        AST_WRITE_WINS: assert property (@(posedge clk) disable iff (!rst_n)
            (hit && $countones(wr_state) == 1) |=> (s == $past(wr_state))); // R9
    end

endmodule

bind mbx_top mbx_top_chk #(
    .NUM_SLOTS (NUM_SLOTS),
    .DATA_W    (DATA_W),
    .ADDR_W    (ADDR_W),
    .WIN_LSB   (WIN_LSB)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_wr    (bus_wr),
    .bus_rd    (bus_rd),
    .bus_addr  (bus_addr),
    .wr_state  (bus_wdata[7:4]),
    .bus_rdata (bus_rdata),
    .rx_slot   (rx_slot),
    .rx_claim  (rx_claim),
    .rx_done   (rx_done),
    .st_flat   (st_flat),
    .ack_flat  (ack_flat)
);

// File: tb/sim_mbx_top.sv
`timescale 1ns/1ps
module sim_mbx_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0, bus_rd = 1'b0;
    logic [10:0] bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [4:0]  rx_slot = '0;
    logic        rx_claim = 1'b0, rx_done = 1'b0;
    logic [31:0] tx_pend, ack_pend;

    int checks = 0;
    int errors = 0;
    bit done_flag = 1'b0;

    always #5 clk = ~clk;

    mbx_top u0 (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .rx_slot(rx_slot), .rx_claim(rx_claim), .rx_done(rx_done),
        .tx_pend(tx_pend), .ack_pend(ack_pend)
    );

    function automatic logic [10:0] ctl(input int s);
        return 11'(s * 64);
    endfunction

    function automatic logic [10:0] dat(input int s, input int w);
        return 11'(s * 64 + 4 + 4 * w);
    endfunction

    task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=0x%08h expected=0x%08h", tag, act, exp);
        end
    endtask

    task automatic bwrite(input logic [10:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic bread(input logic [10:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_rd = 1'b1; bus_addr = a;
        @(negedge clk);
        bus_rd = 1'b0;
        d = bus_rdata;
    endtask

    task automatic strobe(input int s, input bit claim, input bit fin);
        @(negedge clk);
        rx_slot = 5'(s); rx_claim = claim; rx_done = fin;
        @(negedge clk);
        rx_claim = 1'b0; rx_done = 1'b0;
    endtask

    task automatic expect_rd(input logic [10:0] a, input logic [31:0] exp, input string tag);
        logic [31:0] d;
        bread(a, d);
        check(d == exp, tag, d, exp);
    endtask

    task automatic t_reset();
        expect_rd(ctl(0), 32'h10, "R1 slot0 ctl");
        expect_rd(ctl(17), 32'h10, "R1 slot17 ctl");
        expect_rd(ctl(31), 32'h10, "R1 slot31 ctl");
        expect_rd(dat(5, 3), 32'h0, "R1 data word");
        check(tx_pend == 0, "R1 tx_pend", tx_pend, 0);
        check(ack_pend == 0, "R1 ack_pend", ack_pend, 0);
    endtask

    task automatic t_map();
        logic [31:0] d;
        for (int w = 0; w < 8; w++) bwrite(dat(3, w), 32'hA000_0000 + 32'(w));
        bwrite(dat(4, 0), 32'h4444_0000);
        for (int w = 0; w < 8; w++) expect_rd(dat(3, w), 32'hA000_0000 + 32'(w), "R2 slot3 word");
        expect_rd(11'h0E0, 32'hA000_0007, "R2 last word offset 0x20");
        expect_rd(11'h104, 32'h4444_0000, "R2 next window");
        bread(dat(3, 1), d);
        bwrite(dat(3, 1), 32'h5555_5555);
        @(negedge clk);
        check(bus_rdata == d, "R11 rdata held", bus_rdata, d);
    endtask

    task automatic t_mode();
        bwrite(ctl(2), 32'h21);
        expect_rd(ctl(2), 32'h21, "R3 write tx+auto");
        check(tx_pend[2] == 1'b1, "R10 tx_pend set", 32'(tx_pend[2]), 1);
        bwrite(ctl(2), 32'h00);
        expect_rd(ctl(2), 32'h20, "R3 zero state keeps state");
        bwrite(ctl(2), 32'h31);
        expect_rd(ctl(2), 32'h21, "R3 invalid code keeps state");
        bwrite(ctl(2), 32'hFFFF_FF11);
        expect_rd(ctl(2), 32'h11, "R3 upper bits read zero");
        check(tx_pend[2] == 1'b0, "R10 tx_pend clear", 32'(tx_pend[2]), 0);
    endtask

    task automatic t_data_any();
        bwrite(ctl(2), 32'h21);
        bwrite(dat(2, 0), 32'hDEAD_BEEF);
        expect_rd(dat(2, 0), 32'hDEAD_BEEF, "R4 data in tx state");
        bwrite(11'h0A4, 32'h1234_5678);
        expect_rd(11'h0A4, 32'h0, "R4 reserved offset");
        expect_rd(dat(3, 0), 32'hA000_0000, "R4 reserved write no spill");
        bwrite(11'h086, 32'h0BAD_0BAD);
        expect_rd(dat(2, 0), 32'hDEAD_BEEF, "R4 misaligned write ignored");
        expect_rd(11'h086, 32'h0, "R4 misaligned read zero");
        bwrite(ctl(2), 32'h10);
    endtask

    task automatic t_auto();
        bwrite(ctl(7), 32'h21);
        strobe(7, 1'b1, 1'b0);
        expect_rd(ctl(7), 32'h41, "R5 claim to rx");
        check(tx_pend[7] == 1'b0, "R10 tx_pend after claim", 32'(tx_pend[7]), 0);
        strobe(7, 1'b1, 1'b0);
        expect_rd(ctl(7), 32'h41, "R8 claim ignored in rx");
        strobe(7, 1'b0, 1'b1);
        expect_rd(ctl(7), 32'h11, "R6 auto idle from rx");
        bwrite(ctl(7), 32'h21);
        strobe(7, 1'b0, 1'b1);
        expect_rd(ctl(7), 32'h11, "R6 auto idle from tx");
    endtask

    task automatic t_irq();
        bwrite(ctl(9), 32'h20);
        strobe(9, 1'b0, 1'b1);
        expect_rd(ctl(9), 32'h80, "R7 irq mode to ack");
        check(ack_pend == 32'h0000_0200, "R7 ack_pend set", ack_pend, 32'h200);
        bwrite(ctl(9), 32'h10);
        check(ack_pend == 0, "R7 ack_pend cleared", ack_pend, 0);
        expect_rd(ctl(9), 32'h10, "R7 back to idle");
    endtask

    task automatic t_ignore();
        strobe(9, 1'b1, 1'b1);
        expect_rd(ctl(9), 32'h10, "R8 strobes in idle");
        bwrite(ctl(9), 32'h80);
        strobe(9, 1'b1, 1'b1);
        expect_rd(ctl(9), 32'h80, "R8 strobes in ack");
        bwrite(ctl(9), 32'h10);
    endtask

    task automatic t_conflict();
        bwrite(ctl(11), 32'h21);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = ctl(11); bus_wdata = 32'h41;
        rx_slot = 5'd11; rx_done = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0; rx_done = 1'b0;
        expect_rd(ctl(11), 32'h41, "R9 bus write wins");
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = ctl(12); bus_wdata = 32'h21;
        rx_slot = 5'd11; rx_done = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0; rx_done = 1'b0;
        expect_rd(ctl(11), 32'h11, "R9 other slot write no block");
        expect_rd(ctl(12), 32'h21, "R9 other slot written");
        check(tx_pend == 32'h0000_1000, "R10 tx_pend vector", tx_pend, 32'h1000);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_map();
        t_mode();
        t_data_any();
        t_auto();
        t_irq();
        t_ignore();
        t_conflict();
        if (!done_flag) begin
            done_flag = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done_flag) begin
            done_flag = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule